// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits at the back end of a floating-point pipeline and folds the outcome of each finished operation into the floating-point status word. For each finished operation it receives a valid strobe, a five-bit vector of raised IEEE exception conditions and the present status word. It decides whether the operation must trap, writes the per-operation exception field, merges into the sticky (accrued) field when allowed, and marks the trap cause. The block does not do the arithmetic, access the register file or vector the trap.

When the enabled and raised conditions overlap, the block requests a trap and reports exactly one condition, picked by a fixed priority. The sticky field is left alone in that case. When the conditions do not overlap, every raised condition is reported and also accumulated, and the block indicates that the program counter may step past the instruction. The new status word, the trap request and the advance indication all appear one clock after the strobe.

Top module: `fp_exc_recorder`

## Requirements
- R1: While reset is asserted and after reset, `status_out` is zero and `trap_req` and `pc_adv` are low until the first accepted operation.
- R2: Results appear on the clock edge that samples `op_valid` high; while `op_valid` is low, `status_out` keeps its value and `trap_req` and `pc_adv` are low (each is a single-cycle pulse per operation).
- R3: A trap is requested when any bit of `exc_flags` is set whose enable bit is set in the enable field at `status_in` bits 27:23 (flag bit i pairs with status bit 23+i).
- R4: On a trap, the current-exception field (`status_out` bits 4:0) holds exactly one bit: the highest-priority flag among those both raised and enabled, priority invalid (bit 4) > overflow (bit 3) > underflow (bit 2) > divide-by-zero (bit 1) > inexact (bit 0).
- R5: Without a trap, the current-exception field equals `exc_flags` in full, and the accrued field (bits 9:5) becomes the old accrued field ORed with `exc_flags`.
- R6: On a trap, the accrued field is copied unchanged from `status_in`.
- R7: On a trap, the trap-cause field (bits 16:14) is written with 3'b001; without a trap it is copied unchanged.
- R8: `pc_adv` pulses for an accepted operation that does not trap; `trap_req` and `pc_adv` are never high together.
- R9: An operation with no raised flag clears the current-exception field, leaves the accrued field as it was and pulses `pc_adv`.
- R10: All status bits outside fields 4:0, 9:5 and 16:14 are copied from `status_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A floating-point operation has finished this cycle |
| exc_flags | input | 5 | Raised conditions: invalid 4, overflow 3, underflow 2, div-by-zero 1, inexact 0 |
| status_in | input | 64 | Present status word |
| status_out | output | 64 | Updated status word |
| trap_req | output | 1 | One-cycle trap request |
| pc_adv | output | 1 | One-cycle indication that the PC may step past the instruction |

## Verification
The bench targets several flags raised and enabled together, where a design that ORed them all in or used a reversed priority would show several or the wrong bit in the current field. It also raises a high-priority flag that is disabled next to a lower enabled one, where a design that picked before masking would report the disabled condition. Traps with a non-zero accrued field catch a design that still accumulates on a trap, and quiet operations catch a design that touches the sticky field or forgets to clear the current field. Idle cycles between operations catch pulses that stretch and a status word that drifts.

// File: rtl/fp_exc_pkg.sv
package fp_exc_pkg;
    localparam int unsigned EXC_N = 5;
    typedef logic [EXC_N-1:0] exc_vec_t;
    localparam logic [2:0] CAUSE_IEEE = 3'b001;
endpackage

// File: rtl/fp_exc_trap_sel.sv
module fp_exc_trap_sel #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] raised,
    input  logic [N-1:0] enabled,
    output logic         take_trap,
    output logic [N-1:0] pick
);
    logic [N-1:0] hit;

    always_comb begin
        hit       = raised & enabled;
        take_trap = |hit;
        pick      = '0;
        // higher index wins: later iterations overwrite earlier ones
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fp_exc_field_merge.sv
module fp_exc_field_merge
    import fp_exc_pkg::*;
#(
    parameter int unsigned STATUS_W  = 64,
    parameter int unsigned CUR_LSB   = 0,
    parameter int unsigned ACC_LSB   = 5,
    parameter int unsigned CAUSE_LSB = 14
) (
    input  logic [STATUS_W-1:0] status_in,
    input  logic                take_trap,
    input  exc_vec_t            raised,
    input  exc_vec_t            pick,
    output logic [STATUS_W-1:0] status_new
);
    localparam int unsigned CUR_MSB   = CUR_LSB + EXC_N - 1;
    localparam int unsigned ACC_MSB   = ACC_LSB + EXC_N - 1;
    localparam int unsigned CAUSE_MSB = CAUSE_LSB + 2;

    exc_vec_t cur_val;

    always_comb begin
        cur_val    = take_trap ? pick : raised;
        status_new = status_in;
        status_new[CUR_MSB:CUR_LSB] = cur_val;
        if (take_trap) begin
            status_new[CAUSE_MSB:CAUSE_LSB] = CAUSE_IEEE;
        end else begin
            status_new[ACC_MSB:ACC_LSB] = status_in[ACC_MSB:ACC_LSB] | cur_val;
        end
    end
endmodule

// File: rtl/fp_exc_recorder.sv
module fp_exc_recorder
    import fp_exc_pkg::*;
#(
    parameter int unsigned STATUS_W  = 64,
    parameter int unsigned CUR_LSB   = 0,
    parameter int unsigned ACC_LSB   = 5,
    parameter int unsigned CAUSE_LSB = 14,
    parameter int unsigned EN_LSB    = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [4:0]          exc_flags,
    input  logic [STATUS_W-1:0] status_in,
    output logic [STATUS_W-1:0] status_out,
    output logic                trap_req,
    output logic                pc_adv
);
    localparam int unsigned EN_MSB = EN_LSB + EXC_N - 1;

    typedef struct packed {
        logic [STATUS_W-1:0] status;
        logic                trap;
        logic                adv;
    } rec_state_t;

    rec_state_t state_d, state_q;
    logic       take_trap;
    exc_vec_t   pick;
    logic [STATUS_W-1:0] status_new;

    fp_exc_trap_sel #(.N(EXC_N)) u_sel (
        .raised    (exc_flags),
        .enabled   (status_in[EN_MSB:EN_LSB]),
        .take_trap (take_trap),
        .pick      (pick)
    );

    fp_exc_field_merge #(
        .STATUS_W  (STATUS_W),
        .CUR_LSB   (CUR_LSB),
        .ACC_LSB   (ACC_LSB),
        .CAUSE_LSB (CAUSE_LSB)
    ) u_merge (
        .status_in  (status_in),
        .take_trap  (take_trap),
        .raised     (exc_flags),
        .pick       (pick),
        .status_new (status_new)
    );

    always_comb begin
        state_d       = state_q;
        state_d.trap  = 1'b0;
        state_d.adv   = 1'b0;
        if (op_valid) begin
            state_d.status = status_new;
            state_d.trap   = take_trap;
            state_d.adv    = !take_trap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_out = state_q.status;
    assign trap_req   = state_q.trap;
    assign pc_adv     = state_q.adv;
endmodule

// File: rtl/fp_exc_recorder_chk.sv
module fp_exc_recorder_chk #(
    parameter int unsigned STATUS_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [4:0]          exc_flags,
    input logic [STATUS_W-1:0] status_in,
    input logic [STATUS_W-1:0] status_out,
    input logic                trap_req,
    input logic                pc_adv
);
    assert_trap_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((exc_flags & status_in[27:23]) != 5'd0)) |=> trap_req);

    assert_single_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($countones(status_out[4:0]) == 1));

    assert_accrued_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((exc_flags & status_in[27:23]) != 5'd0)) |=> (status_out[9:5] == $past(status_in[9:5])));

    assert_cause_ieee_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (status_out[16:14] == 3'b001));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && pc_adv));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(status_out) && !trap_req && !pc_adv));
endmodule

bind fp_exc_recorder fp_exc_recorder_chk #(.STATUS_W(STATUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .exc_flags  (exc_flags),
    .status_in  (status_in),
    .status_out (status_out),
    .trap_req   (trap_req),
    .pc_adv     (pc_adv)
);

// File: tb/fp_exc_recorder_test.sv
module fp_exc_recorder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  exc_flags = '0;
    logic [63:0] status_in = '0;
    logic [63:0] status_out;
    logic        trap_req, pc_adv;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] exp_status = '0;
    logic        exp_trap = 1'b0;
    logic        exp_adv = 1'b0;
    string       exp_tag = "R1";

    always #2 clk = ~clk;

    fp_exc_recorder uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .exc_flags(exc_flags),
        .status_in(status_in), .status_out(status_out),
        .trap_req(trap_req), .pc_adv(pc_adv)
    );

    task automatic compare();
        checks++;
        if (status_out !== exp_status || trap_req !== exp_trap || pc_adv !== exp_adv) begin
            errors++;
            $display("FAIL %s: got status=%h trap=%b adv=%b expected status=%h trap=%b adv=%b",
                     exp_tag, status_out, trap_req, pc_adv, exp_status, exp_trap, exp_adv);
        end
    endtask

    // behavioural reference of one accepted operation
    task automatic model(input logic v, input logic [4:0] f, input logic [63:0] s, input string tag);
        logic [4:0] en, both, cur;
        exp_tag = tag;
        if (!v) begin
            exp_trap = 0; exp_adv = 0;
            return;
        end
        en   = s[27:23];
        both = f & en;
        exp_status = s;
        if (both != 0) begin
            if (both[4])      cur = 5'b10000; // invalid
            else if (both[3]) cur = 5'b01000; // overflow
            else if (both[2]) cur = 5'b00100; // underflow
            else if (both[1]) cur = 5'b00010; // div-by-zero
            else              cur = 5'b00001; // inexact
            exp_status[4:0]   = cur;
            exp_status[16:14] = 3'd1;
            exp_trap = 1; exp_adv = 0;
        end else begin
            exp_status[4:0] = f;
            exp_status[9:5] = s[9:5] | f;
            exp_trap = 0; exp_adv = 1;
        end
    endtask

    // negedge: check the previous cycle's result, then drive the next inputs
    task automatic cyc(input logic v, input logic [4:0] f, input logic [63:0] s, input string tag);
        @(negedge clk);
        compare();
        op_valid = v; exc_flags = f; status_in = s;
        model(v, f, s, tag);
    endtask

    function automatic logic [63:0] mk(input logic [4:0] en, input logic [4:0] acc,
                                       input logic [2:0] cause, input logic [63:0] other);
        logic [63:0] r;
        r = other & ~64'h0F81_C3FF;
        r[27:23] = en; r[9:5] = acc; r[16:14] = cause; r[4:0] = 5'b10101;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with inputs active during reset
        op_valid = 1; exc_flags = 5'h1F; status_in = '1;
        repeat (3) @(posedge clk);
        exp_tag = "R1";
        @(negedge clk); compare();
        op_valid = 0;
        @(negedge clk); compare();
        rst_n = 1;
        cyc(0, 5'h1F, '1, "R1");
        cyc(0, 5'h00, '0, "R1");
        // R9: no flags
        cyc(1, 5'h00, mk(5'h1F, 5'b01010, 3'd2, 64'hDEAD_BEEF_1234_5678), "R9");
        // R2: idle hold with changing inputs
        cyc(0, 5'h1F, mk(5'h1F, 5'h00, 3'd0, 64'h0), "R2");
        cyc(0, 5'h07, '1, "R2");
        // R5: no trap, flags not enabled
        cyc(1, 5'b10101, mk(5'b01010, 5'b00011, 3'd0, 64'hFFFF_0000_FFFF_0000), "R5");
        // R4: several enabled flags -> invalid wins
        cyc(1, 5'b10001, mk(5'h1F, 5'b11000, 3'd0, 64'h0123_4567_89AB_CDEF), "R4");
        // R4: highest raised not enabled -> div-by-zero
        cyc(1, 5'b01010, mk(5'b00010, 5'b00100, 3'd3, 64'h0), "R4");
        // R6/R7: trap with non-zero accrued
        cyc(1, 5'b00001, mk(5'b00001, 5'b11110, 3'd5, 64'hAAAA_5555_AAAA_5555), "R6");
        // R8 back-to-back: trap then no trap
        cyc(1, 5'b00100, mk(5'b00100, 5'b0, 3'd0, 64'h0), "R8");
        cyc(1, 5'b00100, mk(5'b11011, 5'b0, 3'd7, 64'h0), "R8");
        cyc(0, 5'b0, '0, "R2");
        // R10: other bits pass through
        cyc(1, 5'b00000, mk(5'b0, 5'b0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF), "R10");
        cyc(0, 5'b0, '0, "R10");
        // R3/R7 sweep over flags and enable patterns
        for (int e = 0; e < 32; e += 5) begin
            for (int f = 0; f < 32; f++) begin
                cyc(1, f[4:0], mk(e[4:0], 5'(f * 3), 3'(f), {32'h5A5A_A5A5, 27'd0, f[4:0]}),
                    ((f & e) != 0) ? "R3" : "R5");
            end
            cyc(0, 5'b0, '0, "R2");
        end
        cyc(0, 5'b0, '0, "R2");
        @(negedge clk); compare();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule